// File: doc/BRIEF.md
# Snooping Write-Invalidate Coherence Controller

This block keeps one direct-mapped, write-back cache coherent with its peers on a shared snooping bus. Every line is tracked as Invalid, Shared (clean, possibly held by several caches) or Modified (dirty, held by exactly one cache). Data storage is not modelled. The block holds only the tag and the coherence state per line and decides which bus transactions a processor access needs.

The processor holds a request (address, read or write) until the block returns a one-cycle done pulse with a hit flag. Stall is raised while the block waits for the bus. Bus transactions are one cycle long: the block raises a request with a command and a block address, and the transaction takes place in the cycle where the grant is high. Transactions issued by other caches arrive on the snoop inputs. The block invalidates its copy when a snoop requires it, and it pulses a flush output when its dirty copy must be written back. A combinational probe port reports the state of any block address in this cache.

Addresses are block addresses. The low bits select the line and the high bits form the tag. Command codes on the bus and snoop ports are 0 none, 1 read-miss, 2 write-miss, 3 invalidate and 4 write-back. State codes on the probe port are 0 Invalid, 1 Shared and 2 Modified.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: After reset every address probes as Invalid (0), and done, stall and bus request are all low.
- R2: A read that hits a Shared or Modified line completes in the cycle it is presented, with hit=1, no bus transaction and no state change.
- R3: A read miss issues a read-miss (1) transaction, and the line becomes Shared with the new tag. If the old line was Modified, a write-back (4) transaction carrying the old tag and the same index is issued first.
- R4: A write that misses on the tag issues a write-miss (2) transaction, and the line becomes Modified. A Modified victim is written back (4) first. Done carries hit=0.
- R5: A write that hits a Shared line issues an invalidate (3) transaction, and the line becomes Modified. Done carries hit=1.
- R6: A write that hits a Modified line completes in the cycle it is presented, with hit=1 and no bus transaction.
- R7: A snooped invalidate or write-miss whose address matches a Shared line makes that line Invalid.
- R8: A snooped read-miss or write-miss whose address matches a Modified line raises snoop flush in that cycle, and the line becomes Invalid.
- R9: Snoops are ignored, with no state change and no flush, when they match an Invalid line, miss on the tag, are write-backs, or are read-misses to a Shared line.
- R10: A request that needs the bus keeps stall high until done. Done arrives one cycle after the grant of the last transaction. With grant available, this gives 2 cycles, or 3 cycles with a write-back, after the request is presented; each cycle of grant delay adds one.
- R11: A local request to an index that a snoop changes in the same cycle is not completed in that cycle. It is then served against the updated line.
- R12: In two controllers sharing one bus, no address is ever Modified in one cache while it is valid in the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Processor request, held until done |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | TAG_W+IDX_W | Block address of the request |
| req_done_o | output | 1 | Request completes this cycle |
| req_hit_o | output | 1 | The completing request hit |
| req_stall_o | output | 1 | Request is pending |
| bus_req_o | output | 1 | Bus request |
| bus_gnt_i | input | 1 | Bus grant; the transaction takes place in this cycle |
| bus_cmd_o | output | 3 | Command of the requested transaction |
| bus_addr_o | output | TAG_W+IDX_W | Block address of the requested transaction |
| snp_valid_i | input | 1 | A transaction from another cache takes place |
| snp_cmd_i | input | 3 | Snooped command |
| snp_addr_i | input | TAG_W+IDX_W | Snooped block address |
| snp_flush_o | output | 1 | Dirty copy written back due to this snoop |
| probe_addr_i | input | TAG_W+IDX_W | Address to probe |
| probe_state_o | output | 2 | Coherence state of the probed address |

## Verification
Some properties are checked every cycle. An invalidate from a peer must never find this cache's line Modified. The bus address must stay put while a request waits for grant. Done must follow the grant of the final transaction. The bus must never grant this cache while it is also snooping. The bench's scenarios show the remaining behaviour. It sweeps every address through write/read hand-offs between two caches and then runs a pseudo-random mix with grant delays. For each access it compares hit, latency, bus command sequence, write-back and flush counts, and both caches' probe states against a state model, and checks the single-writer rule after each access. The snoop-versus-local race on one index and simultaneous requests from both caches are set up as directed cases.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    ST_INV = 2'd0,
    ST_SHR = 2'd1,
    ST_MOD = 2'd2
  } line_st_e;

  typedef enum logic [2:0] {
    CMD_NONE   = 3'd0,
    CMD_RDMISS = 3'd1,
    CMD_WRMISS = 3'd2,
    CMD_INVAL  = 3'd3,
    CMD_WBACK  = 3'd4
  } bus_cmd_e;
endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int LINES = 8,
  parameter int TAG_W = 6,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] req_idx_i,
  output logic [TAG_W-1:0] req_tag_o,
  output line_st_e         req_st_o,
  input  logic [IDX_W-1:0] snp_idx_i,
  output logic [TAG_W-1:0] snp_tag_o,
  output line_st_e         snp_st_o,
  input  logic [IDX_W-1:0] prb_idx_i,
  output logic [TAG_W-1:0] prb_tag_o,
  output line_st_e         prb_st_o,
  input  logic             we_i,
  input  logic [IDX_W-1:0] w_idx_i,
  input  logic [TAG_W-1:0] w_tag_i,
  input  line_st_e         w_st_i
);
  logic [TAG_W-1:0] tag_a [LINES];
  line_st_e         st_a  [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [TAG_W-1:0] tag_q;
    line_st_e         st_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_q <= '0;
        st_q  <= ST_INV;
      end else if (we_i && (w_idx_i == IDX_W'(i))) begin
        tag_q <= w_tag_i;
        st_q  <= w_st_i;
      end
    end
    assign tag_a[i] = tag_q;
    assign st_a[i]  = st_q;
  end

  assign req_tag_o = tag_a[req_idx_i];
  assign req_st_o  = st_a[req_idx_i];
  assign snp_tag_o = tag_a[snp_idx_i];
  assign snp_st_o  = st_a[snp_idx_i];
  assign prb_tag_o = tag_a[prb_idx_i];
  assign prb_st_o  = st_a[prb_idx_i];
endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
  import coh_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             snp_valid_i,
  input  bus_cmd_e         snp_cmd_i,
  input  logic [TAG_W-1:0] snp_tag_i,
  input  logic [TAG_W-1:0] line_tag_i,
  input  line_st_e         line_st_i,
  output logic             upd_o,
  output logic             flush_o
);
  logic match;
  logic is_miss;

  assign match   = snp_valid_i && (line_st_i != ST_INV) && (line_tag_i == snp_tag_i);
  assign is_miss = (snp_cmd_i == CMD_RDMISS) || (snp_cmd_i == CMD_WRMISS);
  assign flush_o = match && (line_st_i == ST_MOD) && is_miss;
  // a peer about to own the block must kill our clean copy
  assign upd_o   = flush_o ||
                   (match && (line_st_i == ST_SHR) &&
                    ((snp_cmd_i == CMD_INVAL) || (snp_cmd_i == CMD_WRMISS)));

  // a peer only invalidates from Shared, so our copy cannot be dirty
  assert_single_writer_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_i && (snp_cmd_i == CMD_INVAL) && (line_tag_i == snp_tag_i))
      |-> (line_st_i != ST_MOD));
endmodule

// File: rtl/coh_req_fsm.sv
module coh_req_fsm
  import coh_pkg::*;
#(
  parameter int TAG_W = 6,
  parameter int IDX_W = 3,
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [TAG_W-1:0]  req_tag_i,
  input  logic [IDX_W-1:0]  req_idx_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  line_st_e          line_st_i,
  input  logic              conflict_i,
  output logic              done_o,
  output logic              hit_o,
  output logic              stall_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output bus_cmd_e          bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              we_o,
  output logic [TAG_W-1:0]  w_tag_o,
  output line_st_e          w_st_o
);
  typedef enum logic [1:0] {S_IDLE, S_WB, S_MISS, S_DONE} fsm_e;

  fsm_e state_q, state_d;
  logic hit_q, hit_d;
  logic tag_hit, fast, victim_mod;

  assign tag_hit    = (line_st_i != ST_INV) && (line_tag_i == req_tag_i);
  assign fast       = tag_hit && (!req_write_i || (line_st_i == ST_MOD));
  assign victim_mod = (line_st_i == ST_MOD) && !tag_hit;

  always_comb begin
    state_d    = state_q;
    hit_d      = hit_q;
    done_o     = 1'b0;
    hit_o      = 1'b0;
    stall_o    = 1'b0;
    bus_req_o  = 1'b0;
    bus_cmd_o  = CMD_NONE;
    bus_addr_o = {req_tag_i, req_idx_i};
    we_o       = 1'b0;
    w_tag_o    = line_tag_i;
    w_st_o     = line_st_i;
    unique case (state_q)
      S_IDLE: begin
        if (req_valid_i) begin
          if (conflict_i) begin
            stall_o = 1'b1;
          end else if (fast) begin
            done_o = 1'b1;
            hit_o  = 1'b1;
          end else begin
            stall_o = 1'b1;
            hit_d   = tag_hit;
            state_d = victim_mod ? S_WB : S_MISS;
          end
        end
      end
      S_WB: begin
        stall_o    = 1'b1;
        bus_cmd_o  = CMD_WBACK;
        bus_addr_o = {line_tag_i, req_idx_i};
        // victim may have been flushed by a snoop while waiting
        bus_req_o  = victim_mod;
        if (!victim_mod) begin
          state_d = S_MISS;
        end else if (bus_gnt_i) begin
          we_o    = 1'b1;
          w_st_o  = ST_INV;
          state_d = S_MISS;
        end
      end
      S_MISS: begin
        stall_o   = 1'b1;
        bus_req_o = 1'b1;
        if (!req_write_i)                          bus_cmd_o = CMD_RDMISS;
        else if (tag_hit && line_st_i == ST_SHR)   bus_cmd_o = CMD_INVAL;
        else                                       bus_cmd_o = CMD_WRMISS;
        if (bus_gnt_i) begin
          we_o    = 1'b1;
          w_tag_o = req_tag_i;
          w_st_o  = req_write_i ? ST_MOD : ST_SHR;
          state_d = S_DONE;
        end
      end
      S_DONE: begin
        done_o  = 1'b1;
        hit_o   = hit_q;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      hit_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      hit_q   <= hit_d;
    end
  end

  assert_addr_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_gnt_i) |=> (!bus_req_o || $stable(bus_addr_o)));

  assert_done_after_gnt_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_gnt_i && (bus_cmd_o != CMD_WBACK)) |=> done_o);
endmodule

// File: rtl/snoop_coh_ctrl.sv
module snoop_coh_ctrl
  import coh_pkg::*;
#(
  parameter int LINES = 8,
  parameter int TAG_W = 6,
  localparam int IDX_W  = $clog2(LINES),
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_done_o,
  output logic              req_hit_o,
  output logic              req_stall_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [2:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  input  logic              snp_valid_i,
  input  logic [2:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_flush_o,
  input  logic [ADDR_W-1:0] probe_addr_i,
  output logic [1:0]        probe_state_o
);
  logic [IDX_W-1:0] req_idx, snp_idx, prb_idx;
  logic [TAG_W-1:0] req_tag, snp_tag, prb_tag;
  logic [TAG_W-1:0] rl_tag, sl_tag, pl_tag;
  line_st_e         rl_st, sl_st, pl_st;
  logic             snp_upd, conflict;
  logic             f_we;
  logic [TAG_W-1:0] f_tag;
  line_st_e         f_st;
  bus_cmd_e         f_cmd;
  logic             we;
  logic [IDX_W-1:0] w_idx;
  logic [TAG_W-1:0] w_tag;
  line_st_e         w_st;

  assign req_idx = req_addr_i[IDX_W-1:0];
  assign req_tag = req_addr_i[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr_i[IDX_W-1:0];
  assign snp_tag = snp_addr_i[ADDR_W-1:IDX_W];
  assign prb_idx = probe_addr_i[IDX_W-1:0];
  assign prb_tag = probe_addr_i[ADDR_W-1:IDX_W];

  coh_line_store #(.LINES(LINES), .TAG_W(TAG_W)) u_store (
    .clk_i, .rst_ni,
    .req_idx_i(req_idx), .req_tag_o(rl_tag), .req_st_o(rl_st),
    .snp_idx_i(snp_idx), .snp_tag_o(sl_tag), .snp_st_o(sl_st),
    .prb_idx_i(prb_idx), .prb_tag_o(pl_tag), .prb_st_o(pl_st),
    .we_i(we), .w_idx_i(w_idx), .w_tag_i(w_tag), .w_st_i(w_st)
  );

  coh_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
    .clk_i, .rst_ni,
    .snp_valid_i, .snp_cmd_i(bus_cmd_e'(snp_cmd_i)), .snp_tag_i(snp_tag),
    .line_tag_i(sl_tag), .line_st_i(sl_st),
    .upd_o(snp_upd), .flush_o(snp_flush_o)
  );

  // snoop wins over a local request on the same index
  assign conflict = snp_upd && (snp_idx == req_idx);

  coh_req_fsm #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_fsm (
    .clk_i, .rst_ni,
    .req_valid_i, .req_write_i, .req_tag_i(req_tag), .req_idx_i(req_idx),
    .line_tag_i(rl_tag), .line_st_i(rl_st), .conflict_i(conflict),
    .done_o(req_done_o), .hit_o(req_hit_o), .stall_o(req_stall_o),
    .bus_req_o, .bus_gnt_i, .bus_cmd_o(f_cmd), .bus_addr_o,
    .we_o(f_we), .w_tag_o(f_tag), .w_st_o(f_st)
  );

  assign bus_cmd_o = f_cmd;

  always_comb begin
    if (snp_upd) begin
      we = 1'b1; w_idx = snp_idx; w_tag = sl_tag; w_st = ST_INV;
    end else begin
      we = f_we; w_idx = req_idx; w_tag = f_tag; w_st = f_st;
    end
  end

  assign probe_state_o = ((pl_st != ST_INV) && (pl_tag == prb_tag)) ? pl_st : ST_INV;

  assert_bus_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_gnt_i && snp_valid_i));
endmodule

// File: tb/snoop_coh_ctrl_tb.sv
`timescale 1ns/1ps
module snoop_coh_ctrl_tb;
  localparam int LINES = 4;
  localparam int TAG_W = 2;
  localparam int ADDR_W = 4;
  localparam int NADDR = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0]        rv = '0;
  logic [1:0]        rw = '0;
  logic [ADDR_W-1:0] ra [2];
  logic [ADDR_W-1:0] paddr = '0;
  wire  [1:0]        done_w, hit_w, stall_w, breq_w, flush_w, gnt_w;
  wire  [2:0]        cmd_w [2];
  wire  [ADDR_W-1:0] baddr_w [2];
  wire  [1:0]        pst_w [2];

  int cyc = 0;
  int gnt_after = 0;
  wire en = (cyc >= gnt_after);
  assign gnt_w[0] = breq_w[0] & en;
  assign gnt_w[1] = breq_w[1] & en & ~breq_w[0];

  snoop_coh_ctrl #(.LINES(LINES), .TAG_W(TAG_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(rv[0]), .req_write_i(rw[0]), .req_addr_i(ra[0]),
    .req_done_o(done_w[0]), .req_hit_o(hit_w[0]), .req_stall_o(stall_w[0]),
    .bus_req_o(breq_w[0]), .bus_gnt_i(gnt_w[0]), .bus_cmd_o(cmd_w[0]), .bus_addr_o(baddr_w[0]),
    .snp_valid_i(breq_w[1] & gnt_w[1]), .snp_cmd_i(cmd_w[1]), .snp_addr_i(baddr_w[1]),
    .snp_flush_o(flush_w[0]), .probe_addr_i(paddr), .probe_state_o(pst_w[0])
  );

  snoop_coh_ctrl #(.LINES(LINES), .TAG_W(TAG_W)) u_peer (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(rv[1]), .req_write_i(rw[1]), .req_addr_i(ra[1]),
    .req_done_o(done_w[1]), .req_hit_o(hit_w[1]), .req_stall_o(stall_w[1]),
    .bus_req_o(breq_w[1]), .bus_gnt_i(gnt_w[1]), .bus_cmd_o(cmd_w[1]), .bus_addr_o(baddr_w[1]),
    .snp_valid_i(breq_w[0] & gnt_w[0]), .snp_cmd_i(cmd_w[0]), .snp_addr_i(baddr_w[0]),
    .snp_flush_o(flush_w[1]), .probe_addr_i(paddr), .probe_state_o(pst_w[1])
  );

  int txn [2];
  int wbc [2];
  int flc [2];
  logic [2:0] lastc [2];
  logic [ADDR_W-1:0] lasta [2];
  initial begin
    for (int c = 0; c < 2; c++) begin txn[c] = 0; wbc[c] = 0; flc[c] = 0; lastc[c] = '0; lasta[c] = '0; end
    ra[0] = '0; ra[1] = '0;
  end
  always @(posedge clk) begin
    cyc <= cyc + 1;
    for (int c = 0; c < 2; c++) begin
      if (breq_w[c] && gnt_w[c]) begin
        txn[c] <= txn[c] + 1;
        if (cmd_w[c] == 3'd4) wbc[c] <= wbc[c] + 1;
        lastc[c] <= cmd_w[c];
        lasta[c] <= baddr_w[c];
      end
      if (flush_w[c]) flc[c] <= flc[c] + 1;
    end
  end

  int n_chk = 0;
  int n_fail = 0;
  int mst [2][LINES];
  int mtg [2][LINES];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_states(input string tag);
    int bad [2];
    int fa [2];
    int fe [2];
    int inv_bad;
    inv_bad = 0;
    for (int c = 0; c < 2; c++) begin bad[c] = 0; fa[c] = 0; fe[c] = 0; end
    for (int a = 0; a < NADDR; a++) begin
      paddr = ADDR_W'(a);
      #1;
      for (int c = 0; c < 2; c++) begin
        int e;
        e = (mst[c][a % LINES] != 0 && mtg[c][a % LINES] == a / LINES) ? mst[c][a % LINES] : 0;
        if (int'(pst_w[c]) != e) begin
          if (bad[c] == 0) begin fa[c] = int'(pst_w[c]); fe[c] = e; end
          bad[c]++;
        end
      end
      if ((pst_w[0] == 2'd2 && pst_w[1] != 2'd0) || (pst_w[1] == 2'd2 && pst_w[0] != 2'd0))
        inv_bad++;
    end
    chk(bad[0] == 0, tag, fa[0], fe[0]);
    chk(bad[1] == 0, tag, fa[1], fe[1]);
    chk(inv_bad == 0, "R12", inv_bad, 0);
  endtask

  task automatic resync();
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < LINES; i++) begin mst[c][i] = 0; mtg[c][i] = 0; end
    for (int a = 0; a < NADDR; a++) begin
      paddr = ADDR_W'(a);
      #1;
      for (int c = 0; c < 2; c++)
        if (pst_w[c] != 2'd0) begin mst[c][a % LINES] = int'(pst_w[c]); mtg[c][a % LINES] = a / LINES; end
    end
  endtask

  task automatic do_op(input int c, input int w, input int a, input int d);
    int o, idx, tg, st, ost, ecmd, elat, ewb, etx, eflush, lat, stall_bad;
    int t0, w0, f0, gothit;
    bit th, fast;
    string rtag, otag;
    o = 1 - c; idx = a % LINES; tg = a / LINES;
    st = mst[c][idx];
    th = (st != 0) && (mtg[c][idx] == tg);
    fast = th && (w == 0 || st == 2);
    ewb = (st == 2 && !th) ? 1 : 0;
    ecmd = (w == 0) ? 1 : (th ? 3 : 2);
    elat = fast ? 0 : 2 + ewb + d;
    etx = fast ? 0 : 1 + ewb;
    ost = (mst[o][idx] != 0 && mtg[o][idx] == tg) ? mst[o][idx] : 0;
    eflush = (!fast && ost == 2 && ecmd != 3) ? 1 : 0;
    if (w == 0) rtag = th ? "R2" : "R3";
    else rtag = (th && st == 2) ? "R6" : (th ? "R5" : "R4");
    if (ost == 2 && !fast) otag = "R8";
    else if (ost == 1 && !fast && ecmd != 1) otag = "R7";
    else otag = "R9";
    if (!fast && ost != 0 && (ecmd != 1 || ost == 2)) mst[o][idx] = 0;
    if (!fast) begin mtg[c][idx] = tg; mst[c][idx] = (w != 0) ? 2 : 1; end

    @(negedge clk);
    t0 = txn[c]; w0 = wbc[c]; f0 = flc[o];
    gnt_after = cyc + 1 + d;
    rv[c] = 1'b1; rw[c] = (w != 0); ra[c] = ADDR_W'(a);
    lat = 0; stall_bad = 0;
    forever begin
      #1;
      if (done_w[c]) break;
      if (!stall_w[c]) stall_bad++;
      @(negedge clk);
      lat++;
      if (lat > 40) break;
    end
    gothit = int'(hit_w[c]);
    rv[c] = 1'b0;
    @(negedge clk);
    chk(gothit == (th ? 1 : 0), rtag, gothit, th ? 1 : 0);
    chk(lat == elat, (d > 0 || ewb > 0) ? "R10" : rtag, lat, elat);
    chk(stall_bad == 0, "R10", stall_bad, 0);
    chk(txn[c] - t0 == etx, rtag, txn[c] - t0, etx);
    chk(wbc[c] - w0 == ewb, (w == 0) ? "R3" : "R4", wbc[c] - w0, ewb);
    if (!fast) chk(int'(lastc[c]) == ecmd && int'(lasta[c]) == a, rtag, int'(lastc[c]), ecmd);
    chk(flc[o] - f0 == eflush, eflush != 0 ? "R8" : "R9", flc[o] - f0, eflush);
    check_states(otag);
  endtask

  task automatic run_pair(input int wa, input int aa, input int wb, input int ab);
    int left, guard;
    @(negedge clk);
    gnt_after = 0;
    rv = 2'b11; rw[0] = (wa != 0); rw[1] = (wb != 0); ra[0] = ADDR_W'(aa); ra[1] = ADDR_W'(ab);
    left = 2; guard = 0;
    while (left > 0 && guard < 40) begin
      #1;
      for (int c = 0; c < 2; c++)
        if (rv[c] && done_w[c]) begin rv[c] = 1'b0; left--; end
      @(negedge clk);
      guard++;
    end
    chk(left == 0, "R10", left, 0);
    rv = 2'b00;
    @(negedge clk);
    resync();
    check_states("R12");
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int r;
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < LINES; i++) begin mst[c][i] = 0; mtg[c][i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(stall_w == 2'b00, "R1", int'(stall_w), 0);
    chk(breq_w == 2'b00, "R1", int'(breq_w), 0);
    chk(done_w == 2'b00, "R1", int'(done_w), 0);
    check_states("R1");

    // sweep every address through ownership hand-offs
    for (int a = 0; a < NADDR; a++) begin
      do_op(0, 1, a, 0);
      do_op(1, 0, a, 0);
      do_op(1, 1, a, 1);
      do_op(0, 0, a, 0);
      do_op(0, 0, a, 2);
    end

    // R11 snoop on same index beats local request
    do_op(0, 0, 5, 0);
    do_op(1, 0, 5, 0);
    @(negedge clk);
    gnt_after = 0;
    rv[1] = 1'b1; rw[1] = 1'b1; ra[1] = 4'd5;
    @(negedge clk);
    rv[0] = 1'b1; rw[0] = 1'b0; ra[0] = 4'd5;
    #1;
    chk(done_w[0] == 1'b0, "R11", int'(done_w[0]), 0);
    chk(stall_w[0] == 1'b1, "R11", int'(stall_w[0]), 1);
    @(negedge clk);
    #1;
    chk(done_w[1] == 1'b1, "R5", int'(done_w[1]), 1);
    rv[1] = 1'b0;
    begin
      int g;
      g = 0;
      while (!done_w[0] && g < 40) begin @(negedge clk); #1; g++; end
      chk(done_w[0] == 1'b1 && hit_w[0] == 1'b0, "R11", int'(hit_w[0]), 0);
    end
    rv[0] = 1'b0;
    @(negedge clk);
    mst[0][1] = 1; mtg[0][1] = 1; mst[1][1] = 0;
    check_states("R11");

    // pseudo-random sequential mix with grant delays
    r = 32'h1ace;
    for (int k = 0; k < 300; k++) begin
      r = r ^ (r << 13); r = r ^ (r >>> 17); r = r ^ (r << 5);
      do_op(r & 1, (r >> 1) & 1, (r >> 2) & 15, ((r >> 6) & 3) % 3);
    end

    // simultaneous requests from both caches
    for (int k = 0; k < 60; k++) begin
      r = r ^ (r << 13); r = r ^ (r >>> 17); r = r ^ (r << 5);
      run_pair(r & 1, (r >> 1) & 15, (r >> 5) & 1, ((r >> 6) & 3) * 4 + ((r >> 1) & 3));
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule